// File: doc/BRIEF.md
# I2C Master Command Front-End

This block sits between a processor register bus and a byte-level I2C bus engine. Software programs five registers: own address, clock divider, control, status and data. The block turns accesses to the data and control registers into engine commands: start with an address byte, send a byte, receive a byte, or stop. It tracks whether a transfer is open, keeps the status flags and drives a single interrupt line. The bit-level line engine, the use of the divider value and slave operation are outside this block.

A transfer is driven only by register accesses. Software first sets enable and master in the control register. The first data write then goes out as the address byte, and later data writes send payload bytes. Each data read returns the byte fetched before and then fetches the next one. Status flags are cleared by writing zero to them. Clearing the enable bit performs a soft reset, and the restart bit closes the open transfer so that the next data write addresses a new target.

Both sides use valid/ready handshakes. A register access is a request held on `req_valid` with its address and write data. The block raises `req_ready` for exactly one cycle when the access is complete, and read data and the error flag are valid in that cycle. The requester must hold the request steady until then and drop `req_valid` in the cycle after `req_ready`. An access that needs the engine stalls the register bus until the engine answers. Toward the engine, `eng_cmd_valid` and its opcode and byte stay stable until `eng_cmd_ready`. A response is taken in the cycle where `eng_rsp_valid` and `eng_rsp_ready` are both high.

Top module: `i2cm_front`

## Requirements
- R1: After hardware reset, every register reads 0, `irq` is low and no engine command is issued.
- R2: Register offsets are 0 own address, 1 divider, 2 control, 3 status and 4 data. The own address keeps only bits 7:1 (write mask 0xFE) and the divider keeps bits 5:0. The control register keeps bits 5:0. Bits 15:8 of every read are 0. Offsets 5 to 7 read 0, and writes to them change nothing.
- R3: Control bit 0 is enable and bit 1 is interrupt enable. The interrupt is raised only when both are set. Raising it sets status bit 1 and drives `irq` high.
- R4: Control bit 2 selects master. Writing it as 1 sets status bit 3 (busy). Writing it as 0 clears busy, and if a transfer is open, issues a stop command (opcode 3) and closes the transfer.
- R5: A control write with bit 5 (restart) set while a transfer is open issues stop, closes the transfer and leaves bit 5 reading 0. The next data write then sends a start. With no open transfer, bit 5 is stored as written.
- R6: Status bit 1 (interrupt pending) and bit 2 (arbitration lost) are cleared only by writing 0 to a set flag. Clearing bit 1 drops `irq`. Writing 1 has no effect, and the other status bits cannot be written.
- R7: A control write that clears bit 0 while enable is set is a soft reset. It issues stop if a transfer is open and returns every register to 0 except the own address.
- R8: With enable clear, a data write issues no engine command.
- R9: In master mode with no open transfer, a data write issues start (opcode 0) with the byte. The byte's bits 7:1 are the target and bit 0 is the direction. On NACK, status bit 0 is set and no transfer opens. On ACK, bit 0 is cleared, the transfer opens and the interrupt is raised.
- R10: A data write during an open transfer issues send (opcode 1) with the byte. On NACK, the block sets status bit 0, issues stop and closes the transfer. On ACK, it clears bit 0 and raises the interrupt.
- R11: A master-mode data read returns the byte received before, then issues receive (opcode 2), stores the returned byte and raises the interrupt. If no transfer is open or control bit 3 (transmit) is set, no command is issued and `req_err` is high.
- R12: With master clear, data writes and reads issue no engine command and reads report no error.
- R13: Each access issues exactly the commands its case calls for. A command stays stable until accepted, and `req_ready` is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Register access request |
| req_ready | output | 1 | Access complete, one-cycle pulse |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 3 | Register offset |
| req_wdata | input | 8 | Write data |
| req_rdata | output | 16 | Read data, valid with req_ready |
| req_err | output | 1 | Data read refused, valid with req_ready |
| irq | output | 1 | Interrupt line |
| eng_cmd_valid | output | 1 | Engine command valid |
| eng_cmd_ready | input | 1 | Engine accepts command |
| eng_cmd_op | output | 2 | 0 start, 1 send, 2 receive, 3 stop |
| eng_cmd_byte | output | 8 | Address or data byte |
| eng_rsp_valid | input | 1 | Engine response valid |
| eng_rsp_ready | output | 1 | Block accepts response |
| eng_rsp_nack | input | 1 | 1 = byte not acknowledged |
| eng_rsp_byte | input | 8 | Received byte |

## Verification
The assertions watch the engine handshake on every cycle. Once raised, a command must hold its opcode and byte until it is accepted. A command and a response wait must never overlap. `req_ready` must be a single-cycle pulse, `irq` may rise only under enable plus interrupt enable, and a data write with enable clear must launch no command. The open/closed transfer sequencing needs the bench's scenarios to show it: address NACK against ACK, send NACK with its extra stop, restart, master drop, soft reset, and the previous-byte behaviour of reads. The bench shows these by logging every command the engine model accepts and comparing the log and the status reads with its own expectations.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_SEND  = 2'd1,
    OP_RECV  = 2'd2,
    OP_STOP  = 2'd3
  } eng_op_e;

  typedef enum logic [1:0] {
    T_IDLE = 2'd0,
    T_WAIT = 2'd1,
    T_ACK  = 2'd2
  } tstate_e;

  typedef enum logic [1:0] {
    K_STOP = 2'd0,
    K_ADDR = 2'd1,
    K_SEND = 2'd2,
    K_RECV = 2'd3
  } kind_e;

  // control bits
  localparam int CTL_EN    = 0;
  localparam int CTL_IE    = 1;
  localparam int CTL_MS    = 2;
  localparam int CTL_TX    = 3;
  localparam int CTL_NOACK = 4;
  localparam int CTL_RS    = 5;
  localparam int CTL_W     = 6;

  // status bits
  localparam int ST_NACK = 0;
  localparam int ST_IRQ  = 1;
  localparam int ST_ARB  = 2;
  localparam int ST_BUSY = 3;
  localparam int ST_W    = 4;

  // register offsets
  localparam logic [2:0] REG_OWN  = 3'd0;
  localparam logic [2:0] REG_DIV  = 3'd1;
  localparam logic [2:0] REG_CTL  = 3'd2;
  localparam logic [2:0] REG_STAT = 3'd3;
  localparam logic [2:0] REG_DATA = 3'd4;
endpackage

// File: rtl/i2cm_eng_port.sv
module i2cm_eng_port
  import i2cm_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch,
  input  eng_op_e           l_op,
  input  logic [BYTE_W-1:0] l_byte,
  output logic              done,
  output logic              eng_cmd_valid,
  input  logic              eng_cmd_ready,
  output logic [1:0]        eng_cmd_op,
  output logic [BYTE_W-1:0] eng_cmd_byte,
  input  logic              eng_rsp_valid,
  output logic              eng_rsp_ready
);
  typedef enum logic [1:0] {P_IDLE, P_CMD, P_RESP} pstate_e;

  pstate_e           ps;
  eng_op_e           op_q;
  logic [BYTE_W-1:0] byte_q;

  assign done          = (ps == P_RESP) && eng_rsp_valid;
  assign eng_cmd_valid = (ps == P_CMD);
  assign eng_rsp_ready = (ps == P_RESP);
  assign eng_cmd_op    = op_q;
  assign eng_cmd_byte  = byte_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ps     <= P_IDLE;
      op_q   <= OP_START;
      byte_q <= '0;
    end else begin
      if (launch && (ps == P_IDLE || done)) begin
        op_q   <= l_op;
        byte_q <= l_byte;
      end
      case (ps)
        P_IDLE:  if (launch) ps <= P_CMD;
        P_CMD:   if (eng_cmd_ready) ps <= P_RESP;
        P_RESP:  if (eng_rsp_valid) ps <= launch ? P_CMD : P_IDLE;
        default: ps <= P_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/i2cm_rd_mux.sv
module i2cm_rd_mux
  import i2cm_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int DIV_W  = 6,
  parameter int RD_W   = 16
) (
  input  logic [2:0]        idx,
  input  logic [BYTE_W-1:0] own,
  input  logic [DIV_W-1:0]  div,
  input  logic [CTL_W-1:0]  ctl,
  input  logic [ST_W-1:0]   stat,
  input  logic [BYTE_W-1:0] rx,
  output logic [RD_W-1:0]   rdata
);
  always_comb begin
    rdata = '0;
    case (idx)
      REG_OWN:  rdata[BYTE_W-1:0] = own;
      REG_DIV:  rdata[DIV_W-1:0]  = div;
      REG_CTL:  rdata[CTL_W-1:0]  = ctl;
      REG_STAT: rdata[ST_W-1:0]   = stat;
      REG_DATA: rdata[BYTE_W-1:0] = rx;
      default:  rdata = '0;
    endcase
  end
endmodule

// File: rtl/i2cm_front.sv
module i2cm_front
  import i2cm_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int DIV_W  = 6,
  parameter int RD_W   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [2:0]        req_addr,
  input  logic [BYTE_W-1:0] req_wdata,
  output logic [RD_W-1:0]   req_rdata,
  output logic              req_err,
  output logic              irq,
  output logic              eng_cmd_valid,
  input  logic              eng_cmd_ready,
  output logic [1:0]        eng_cmd_op,
  output logic [BYTE_W-1:0] eng_cmd_byte,
  input  logic              eng_rsp_valid,
  output logic              eng_rsp_ready,
  input  logic              eng_rsp_nack,
  input  logic [BYTE_W-1:0] eng_rsp_byte
);
  localparam logic [BYTE_W-1:0] OWN_MASK = {{(BYTE_W-1){1'b1}}, 1'b0};

  tstate_e           ts;
  kind_e             kind;
  logic [BYTE_W-1:0] own_q, rx_q;
  logic [DIV_W-1:0]  div_q;
  logic [CTL_W-1:0]  ctl_q;
  logic              st_nack, st_irq, st_arb, st_busy, open_q;
  logic [RD_W-1:0]   rdata_q, mux_rdata;
  logic              err_q;
  logic [ST_W-1:0]   stat_v;

  logic              acc, wr_ctl, srst, ctl_norm, ms_off_stop, rs_stop;
  logic              dw, dr_ok, dr_err, nack_stop, launch, done, raise;
  eng_op_e           l_op;
  kind_e             l_kind;

  assign stat_v = {st_busy, st_arb, st_irq, st_nack};
  assign raise  = ctl_q[CTL_EN] && ctl_q[CTL_IE];

  // access decode
  always_comb begin
    acc         = (ts == T_IDLE) && req_valid;
    wr_ctl      = acc && req_write && (req_addr == REG_CTL);
    srst        = wr_ctl && ctl_q[CTL_EN] && !req_wdata[CTL_EN];
    ctl_norm    = wr_ctl && !srst;
    ms_off_stop = ctl_norm && !req_wdata[CTL_MS] && open_q;
    rs_stop     = ctl_norm && req_wdata[CTL_MS] && req_wdata[CTL_RS] && open_q;
    dw          = acc && req_write && (req_addr == REG_DATA) &&
                  ctl_q[CTL_EN] && ctl_q[CTL_MS];
    dr_ok       = acc && !req_write && (req_addr == REG_DATA) && ctl_q[CTL_MS] &&
                  open_q && !ctl_q[CTL_TX];
    dr_err      = acc && !req_write && (req_addr == REG_DATA) && ctl_q[CTL_MS] &&
                  !(open_q && !ctl_q[CTL_TX]);
    nack_stop   = (ts == T_WAIT) && done && (kind == K_SEND) && eng_rsp_nack;
    launch      = (srst && open_q) || ms_off_stop || rs_stop || dw || dr_ok || nack_stop;
    if (dw) begin
      l_op   = open_q ? OP_SEND : OP_START;
      l_kind = open_q ? K_SEND : K_ADDR;
    end else if (dr_ok) begin
      l_op   = OP_RECV;
      l_kind = K_RECV;
    end else begin
      l_op   = OP_STOP;
      l_kind = K_STOP;
    end
  end

  i2cm_eng_port #(.BYTE_W(BYTE_W)) u_port (
    .clk           (clk),
    .rst_n         (rst_n),
    .launch        (launch),
    .l_op          (l_op),
    .l_byte        (dw ? req_wdata : '0),
    .done          (done),
    .eng_cmd_valid (eng_cmd_valid),
    .eng_cmd_ready (eng_cmd_ready),
    .eng_cmd_op    (eng_cmd_op),
    .eng_cmd_byte  (eng_cmd_byte),
    .eng_rsp_valid (eng_rsp_valid),
    .eng_rsp_ready (eng_rsp_ready)
  );

  i2cm_rd_mux #(.BYTE_W(BYTE_W), .DIV_W(DIV_W), .RD_W(RD_W)) u_mux (
    .idx   (req_addr),
    .own   (own_q),
    .div   (div_q),
    .ctl   (ctl_q),
    .stat  (stat_v),
    .rx    (rx_q),
    .rdata (mux_rdata)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ts      <= T_IDLE;
      kind    <= K_STOP;
      own_q   <= '0;
      div_q   <= '0;
      ctl_q   <= '0;
      rx_q    <= '0;
      st_nack <= 1'b0;
      st_irq  <= 1'b0;
      st_arb  <= 1'b0;
      st_busy <= 1'b0;
      open_q  <= 1'b0;
      rdata_q <= '0;
      err_q   <= 1'b0;
    end else begin
      case (ts)
        T_IDLE: if (acc) begin
          rdata_q <= mux_rdata;
          err_q   <= dr_err;
          kind    <= l_kind;
          ts      <= launch ? T_WAIT : T_ACK;
          if (req_write) begin
            case (req_addr)
              REG_OWN: own_q <= req_wdata & OWN_MASK;
              REG_DIV: div_q <= req_wdata[DIV_W-1:0];
              REG_CTL: begin
                if (srst) begin
                  ctl_q   <= '0;
                  div_q   <= '0;
                  rx_q    <= '0;
                  st_nack <= 1'b0;
                  st_irq  <= 1'b0;
                  st_arb  <= 1'b0;
                  st_busy <= 1'b0;
                  open_q  <= 1'b0;
                end else begin
                  ctl_q <= req_wdata[CTL_W-1:0];
                  if (rs_stop) ctl_q[CTL_RS] <= 1'b0;
                  st_busy <= req_wdata[CTL_MS];
                  if (ms_off_stop || rs_stop) open_q <= 1'b0;
                end
              end
              REG_STAT: begin
                if (st_irq && !req_wdata[ST_IRQ]) st_irq <= 1'b0;
                if (st_arb && !req_wdata[ST_ARB]) st_arb <= 1'b0;
              end
              default: ;
            endcase
          end
        end
        T_WAIT: if (done) begin
          ts <= nack_stop ? T_WAIT : T_ACK;
          if (nack_stop) kind <= K_STOP;
          case (kind)
            K_ADDR: begin
              if (eng_rsp_nack) st_nack <= 1'b1;
              else begin
                st_nack <= 1'b0;
                open_q  <= 1'b1;
                if (raise) st_irq <= 1'b1;
              end
            end
            K_SEND: begin
              if (eng_rsp_nack) begin
                st_nack <= 1'b1;
                open_q  <= 1'b0;
              end else begin
                st_nack <= 1'b0;
                if (raise) st_irq <= 1'b1;
              end
            end
            K_RECV: begin
              rx_q <= eng_rsp_byte;
              if (raise) st_irq <= 1'b1;
            end
            default: ;
          endcase
        end
        T_ACK:   ts <= T_IDLE;
        default: ts <= T_IDLE;
      endcase
    end
  end

  assign req_ready = (ts == T_ACK);
  assign req_rdata = rdata_q;
  assign req_err   = err_q;
  assign irq       = st_irq;
endmodule

// File: rtl/i2cm_front_chk.sv
module i2cm_front_chk #(
  parameter int CW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic          req_write,
  input logic [2:0]    req_addr,
  input logic          irq,
  input logic          eng_cmd_valid,
  input logic          eng_cmd_ready,
  input logic [1:0]    eng_cmd_op,
  input logic [7:0]    eng_cmd_byte,
  input logic          eng_rsp_ready,
  input logic [CW-1:0] ctl_q,
  input logic [1:0]    ts
);
  assert_cmd_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_cmd_valid && !eng_cmd_ready) |=>
      (eng_cmd_valid && $stable(eng_cmd_op) && $stable(eng_cmd_byte)));

  assert_no_overlap_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !(eng_cmd_valid && eng_rsp_ready));

  assert_ready_pulse_R13: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |=> !req_ready);

  assert_irq_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(ctl_q[0] && ctl_q[1]));

  assert_disabled_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ts == 2'd0 && req_valid && req_write && req_addr == 3'd4 && !ctl_q[0])
      |=> !eng_cmd_valid);
endmodule

bind i2cm_front i2cm_front_chk #(.CW(6)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_valid     (req_valid),
  .req_ready     (req_ready),
  .req_write     (req_write),
  .req_addr      (req_addr),
  .irq           (irq),
  .eng_cmd_valid (eng_cmd_valid),
  .eng_cmd_ready (eng_cmd_ready),
  .eng_cmd_op    (eng_cmd_op),
  .eng_cmd_byte  (eng_cmd_byte),
  .eng_rsp_ready (eng_rsp_ready),
  .ctl_q         (ctl_q),
  .ts            (ts)
);

// File: tb/i2cm_front_test.sv
`timescale 1ns/1ps
module i2cm_front_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [2:0]  req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        req_ready, req_err, irq;
  logic [15:0] req_rdata;
  logic        eng_cmd_valid, eng_rsp_ready;
  logic        eng_cmd_ready = 1'b0, eng_rsp_valid = 1'b0, eng_rsp_nack = 1'b0;
  logic [1:0]  eng_cmd_op;
  logic [7:0]  eng_cmd_byte, eng_rsp_byte = '0;

  int          n_chk = 0, n_err = 0, n_cmd = 0, cycles = 0;
  logic [1:0]  log_op [64];
  logic [7:0]  log_byte [64];
  logic        next_nack = 1'b0;
  logic [7:0]  next_rx = '0;
  logic        finished = 1'b0;

  always #2.5 clk = ~clk;

  i2cm_front uut (.*);

  // engine model
  initial begin
    forever begin
      @(negedge clk);
      if (eng_cmd_valid) begin
        repeat ($urandom % 3) @(negedge clk);
        log_op[n_cmd % 64]   = eng_cmd_op;
        log_byte[n_cmd % 64] = eng_cmd_byte;
        n_cmd++;
        eng_cmd_ready = 1'b1;
        @(negedge clk);
        eng_cmd_ready = 1'b0;
        repeat ($urandom % 3) @(negedge clk);
        eng_rsp_nack  = (log_op[(n_cmd-1) % 64] <= 2'd1) ? next_nack : 1'b0;
        eng_rsp_byte  = next_rx;
        eng_rsp_valid = 1'b1;
        while (!eng_rsp_ready) @(negedge clk);
        @(negedge clk);
        eng_rsp_valid = 1'b0;
      end
    end
  end

  task automatic chk(input string tag, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_err++;
      $display("FAIL %s got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  task automatic bus(input logic wr, input logic [2:0] a, input logic [7:0] d,
                     output logic [15:0] rd, output logic er);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    do @(negedge clk); while (!req_ready);
    rd = req_rdata; er = req_err;
    req_valid = 1'b0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    logic [15:0] r; logic e;
    bus(1'b1, a, d, r, e);
  endtask

  task automatic rd_chk(input string tag, input logic [2:0] a, input int exp);
    logic [15:0] r; logic e;
    bus(1'b0, a, 8'h00, r, e);
    chk(tag, int'(r), exp);
  endtask

  function automatic int stat(input bit busy, input bit irqp, input bit nack);
    return (int'(busy) << 3) | (int'(irqp) << 1) | int'(nack);
  endfunction

  task automatic last_cmd(input string tag, input int back, input int op, input int b);
    chk({tag, " op"}, int'(log_op[(n_cmd-back) % 64]), op);
    if (b >= 0) chk({tag, " byte"}, int'(log_byte[(n_cmd-back) % 64]), b);
  endtask

  // watchdog
  initial begin
    while (cycles < 100000 && !finished) begin @(posedge clk); cycles++; end
    if (!finished) begin
      n_err++; n_chk++;
      $display("FAIL watchdog got %0d cycles expected completion", cycles);
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [15:0] r; logic e; int c0; bit open, irqp;
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int i = 0; i < 5; i++) rd_chk("R1 reset read", 3'(i), 0);
    chk("R1 irq", int'(irq), 0);
    chk("R1 no command", n_cmd, 0);

    // R2 masking and holes
    wr(3'd0, 8'hFF); rd_chk("R2 own mask", 3'd0, 'hFE);
    wr(3'd1, 8'hFF); rd_chk("R2 div mask", 3'd1, 'h3F);
    wr(3'd2, 8'hC0); rd_chk("R2 ctl mask", 3'd2, 'h00);
    wr(3'd5, 8'hFF); rd_chk("R2 hole read", 3'd5, 0);
    rd_chk("R2 hole write ignored", 3'd0, 'hFE);

    // R8 disabled data write
    wr(3'd2, 8'h04);
    rd_chk("R4 busy set disabled", 3'd3, stat(1, 0, 0));
    c0 = n_cmd; wr(3'd4, 8'hA0);
    chk("R8 disabled write no cmd", n_cmd - c0, 0);
    wr(3'd2, 8'h00);

    // R4 master on
    wr(3'd2, 8'h07);
    rd_chk("R4 busy", 3'd3, stat(1, 0, 0));

    // R9 address NACK then ACK
    next_nack = 1'b1; c0 = n_cmd; wr(3'd4, 8'hA0);
    chk("R9 nack one cmd", n_cmd - c0, 1);
    last_cmd("R9 nack start", 1, 0, 'hA0);
    rd_chk("R9 nack status", 3'd3, stat(1, 0, 1));
    chk("R9 nack irq", int'(irq), 0);
    next_nack = 1'b0; wr(3'd4, 8'hA0);
    last_cmd("R9 ack start", 1, 0, 'hA0);
    rd_chk("R9 ack status", 3'd3, stat(1, 1, 0));
    chk("R3 irq raised", int'(irq), 1);

    // R6 status clear
    wr(3'd3, 8'h0F); rd_chk("R6 write one no effect", 3'd3, stat(1, 1, 0));
    wr(3'd3, 8'h00); rd_chk("R6 write zero clears", 3'd3, stat(1, 0, 0));
    chk("R6 irq drop", int'(irq), 0);

    // R10 send ACK / NACK
    wr(3'd4, 8'h55);
    last_cmd("R10 send", 1, 1, 'h55);
    rd_chk("R10 ack status", 3'd3, stat(1, 1, 0));
    wr(3'd3, 8'h00);
    next_nack = 1'b1; c0 = n_cmd; wr(3'd4, 8'h66); next_nack = 1'b0;
    chk("R10 nack two cmds", n_cmd - c0, 2);
    last_cmd("R10 nack send", 2, 1, 'h66);
    last_cmd("R10 nack stop", 1, 3, -1);
    rd_chk("R10 nack status", 3'd3, stat(1, 0, 1));

    // R11 read with no open transfer
    c0 = n_cmd; bus(1'b0, 3'd4, 8'h00, r, e);
    chk("R11 closed read err", int'(e), 1);
    chk("R11 closed read no cmd", n_cmd - c0, 0);

    // R11 read sequence
    wr(3'd4, 8'hA1); last_cmd("R9 reopen start", 1, 0, 'hA1);
    wr(3'd3, 8'h00);
    next_rx = 8'h3C; bus(1'b0, 3'd4, 8'h00, r, e);
    chk("R11 first read old byte", int'(r), 0);
    chk("R11 first read no err", int'(e), 0);
    last_cmd("R11 recv", 1, 2, -1);
    next_rx = 8'h99; bus(1'b0, 3'd4, 8'h00, r, e);
    chk("R11 second read", int'(r), 'h3C);
    rd_chk("R11 irq status", 3'd3, stat(1, 1, 0));
    wr(3'd3, 8'h00);
    wr(3'd2, 8'h0F); c0 = n_cmd; bus(1'b0, 3'd4, 8'h00, r, e);
    chk("R11 tx read err", int'(e), 1);
    chk("R11 tx read no cmd", n_cmd - c0, 0);
    wr(3'd2, 8'h07);

    // R5 restart
    c0 = n_cmd; wr(3'd2, 8'h27);
    chk("R5 stop issued", n_cmd - c0, 1);
    last_cmd("R5 stop", 1, 3, -1);
    rd_chk("R5 bit self clear", 3'd2, 'h07);
    c0 = n_cmd; wr(3'd2, 8'h27);
    chk("R5 idle no cmd", n_cmd - c0, 0);
    rd_chk("R5 bit kept idle", 3'd2, 'h27);
    wr(3'd2, 8'h07);
    wr(3'd4, 8'hB0); last_cmd("R5 new start", 1, 0, 'hB0);

    // R4 master drop with open transfer
    c0 = n_cmd; wr(3'd2, 8'h03);
    chk("R4 stop count", n_cmd - c0, 1);
    last_cmd("R4 stop", 1, 3, -1);
    rd_chk("R4 busy cleared", 3'd3, stat(0, 1, 0));
    wr(3'd3, 8'h00);

    // R12 slave mode
    c0 = n_cmd; wr(3'd4, 8'h11); bus(1'b0, 3'd4, 8'h00, r, e);
    chk("R12 no cmd", n_cmd - c0, 0);
    chk("R12 no err", int'(e), 0);

    // R3 gating
    wr(3'd2, 8'h05); wr(3'd4, 8'hA0);
    rd_chk("R3 gated status", 3'd3, stat(1, 0, 0));
    chk("R3 gated irq", int'(irq), 0);

    // R7 soft reset with open transfer
    wr(3'd0, 8'h42); wr(3'd1, 8'h15);
    c0 = n_cmd; wr(3'd2, 8'h00);
    chk("R7 stop count", n_cmd - c0, 1);
    last_cmd("R7 stop", 1, 3, -1);
    rd_chk("R7 own kept", 3'd0, 'h42);
    rd_chk("R7 div cleared", 3'd1, 0);
    rd_chk("R7 ctl cleared", 3'd2, 0);
    rd_chk("R7 status cleared", 3'd3, 0);
    rd_chk("R7 rx cleared", 3'd4, 0);

    // random traffic: R9, R10, R13
    wr(3'd2, 8'h07); open = 0; irqp = 0;
    for (int i = 0; i < 40; i++) begin
      logic [7:0] b; bit n; int d;
      b = 8'($urandom); n = ($urandom % 4) == 0;
      next_nack = n; c0 = n_cmd; wr(3'd4, b); next_nack = 1'b0;
      d = n_cmd - c0;
      if (open) begin
        chk("R13 send count", d, n ? 2 : 1);
        last_cmd("R10 rnd send", n ? 2 : 1, 1, int'(b));
        if (n) begin last_cmd("R10 rnd stop", 1, 3, -1); open = 0; end
      end else begin
        chk("R13 start count", d, 1);
        last_cmd("R9 rnd start", 1, 0, int'(b));
        open = !n;
      end
      if (!n) irqp = 1;
      rd_chk("R10 rnd status", 3'd3, stat(1, irqp, n));
    end

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule